// File: doc/BRIEF.md
# Pipelined Montgomery Modular Multiplier Array

This block multiplies two multi-digit integers modulo an odd modulus in Montgomery form. It returns a value X with X·r^(n+1) ≡ A·B (mod M), where r = 2^DW is the digit radix and n is the operand digit count. The work is spread over a two-dimensional grid of digit cells. There is one row per reduction step (n+1 rows) and one column per digit position. In the first column each row picks its quotient digit from the lowest digit of its incoming partial product. Quotient digits and carries therefore both move from low to high digit positions, so no redundant number system is needed.

Operands arrive as whole words with a valid flag. Inside the block, short delay lines skew the digits in time: digit j of B and M is delayed by j cycles, and multiplier digit i by 2i cycles. Result digits leave the bottom row one after another and are realigned into a whole word. A new multiplication can start on every clock cycle. Every result appears a fixed number of cycles after its operands were accepted. The caller supplies the precomputed digit (r − M mod r)^-1 mod r next to the operands. Leaving the Montgomery domain and subtracting the final extra modulus are left to the caller.

Top module: `mont_systolic_mul`

## Requirements
- R1: For an accepted operation with odd M, A < r^n and B < 2M, the result X satisfies X·r^(n+1) mod M = A·B mod M and X < 2M.
- R2: An operation can be accepted on every cycle. Results leave in the order in which their operations were accepted, one result per accepted operation.
- R3: No carry leaves the highest digit column of any row.
- R4: `out_valid` and its result appear exactly 3n+4 clock edges after the edge that sampled `in_valid` high.
- R5: `out_valid` is the `in_valid` sequence delayed by exactly 3n+4 cycles. A cycle with `in_valid` low produces no result.
- R6: While `rst_n` is low, `out_valid` and `out_p` are zero. Operations still in flight when reset is applied produce no result afterwards.
- R7: `out_p` holds n+2 digits, with digit k at bits [k·DW +: DW] weighted r^k. When `out_valid` is high, the top digit k = n+1 is zero.
- R8: If A = 0 or B = 0, the result is exactly zero.
- R9: M must be odd. When M = 1 the result is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on this cycle start a multiplication |
| in_a | input | ND·DW | Multiplier A, digit i at bits [i·DW +: DW] |
| in_b | input | (ND+1)·DW | Multiplicand B, below 2M, same digit layout |
| in_m | input | ND·DW | Odd modulus M, same digit layout |
| in_minv | input | DW | (r − M mod r)^-1 mod r |
| out_valid | output | 1 | `out_p` carries a finished result |
| out_p | output | (ND+2)·DW | Montgomery product X, below 2M |

## Verification
Two functions can fall in the same cycle: accepting a new operation, and emitting the result of an earlier one. A stream of operations longer than the latency, with idle cycles mixed in, makes these cycles overlap. Each emitted result is then checked against the oldest pending operation, both for its value and for the exact cycle distance from its acceptance. Reset applied while operations are still inside the grid is the second collision. It is judged by requiring silence on `out_valid` for more than one full latency after reset is released.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int DIGIT_W_DEF  = 2;
    localparam int N_DIGITS_DEF = 4;

    // carry of one cell never exceeds 2r-1
    function automatic int carry_width(input int dw);
        return dw + 1;
    endfunction

    // end-to-end latency including input skew and output alignment
    function automatic int pipe_latency(input int nd);
        return 3 * nd + 4;
    endfunction
endpackage

// File: rtl/mm_delay.sv
module mm_delay #(
    parameter int W = 2,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (D == 0) begin : g_wire
            assign dout = din;
        end else begin : g_pipe
            logic [W-1:0] pipe_d [D];
            logic [W-1:0] pipe_q [D];

            always_comb begin
                pipe_d[0] = din;
                for (int k = 1; k < D; k++) begin
                    pipe_d[k] = pipe_q[k-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < D; k++) pipe_q[k] <= '0;
                end else begin
                    for (int k = 0; k < D; k++) pipe_q[k] <= pipe_d[k];
                end
            end

            assign dout = pipe_q[D-1];
        end
    endgenerate
endmodule

// File: rtl/mm_qcell.sv
module mm_qcell import mm_pkg::*; #(
    parameter int DW = DIGIT_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DW-1:0]             p_in,
    input  logic [DW-1:0]             a_in,
    input  logic [DW-1:0]             b_in,
    input  logic [DW-1:0]             m_in,
    input  logic [DW-1:0]             k_in,
    input  logic                      v_in,
    output logic [DW-1:0]             a_out,
    output logic [DW-1:0]             q_out,
    output logic [carry_width(DW)-1:0] c_out,
    output logic [DW-1:0]             b_out,
    output logic [DW-1:0]             m_out,
    output logic [DW-1:0]             k_out,
    output logic                      v_out
);
    localparam int CW = carry_width(DW);
    localparam int SW = 2 * DW + 1;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] q;
        logic [CW-1:0] c;
        logic [DW-1:0] b1;
        logic [DW-1:0] b2;
        logic [DW-1:0] m1;
        logic [DW-1:0] m2;
        logic [DW-1:0] k1;
        logic [DW-1:0] k2;
        logic          v1;
        logic          v2;
    } qst_t;

    qst_t          st_d, st_q;
    logic [DW-1:0] lo_d;
    logic [DW-1:0] qd_d;
    logic [SW-1:0] full_d;

    always_comb begin
        st_d   = st_q;
        lo_d   = p_in + a_in * b_in;
        qd_d   = lo_d * k_in;
        full_d = SW'(p_in) + SW'(a_in) * SW'(b_in) + SW'(qd_d) * SW'(m_in);
        st_d.a  = a_in;
        st_d.q  = qd_d;
        st_d.c  = full_d[SW-1:DW];
        st_d.b1 = b_in;
        st_d.b2 = st_q.b1;
        st_d.m1 = m_in;
        st_d.m2 = st_q.m1;
        st_d.k1 = k_in;
        st_d.k2 = st_q.k1;
        st_d.v1 = v_in;
        st_d.v2 = st_q.v1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_out = st_q.a;
    assign q_out = st_q.q;
    assign c_out = st_q.c;
    assign b_out = st_q.b2;
    assign m_out = st_q.m2;
    assign k_out = st_q.k2;
    assign v_out = st_q.v2;
endmodule

// File: rtl/mm_cell.sv
module mm_cell import mm_pkg::*; #(
    parameter int DW = DIGIT_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DW-1:0]             p_in,
    input  logic [DW-1:0]             a_in,
    input  logic [DW-1:0]             q_in,
    input  logic [carry_width(DW)-1:0] c_in,
    input  logic [DW-1:0]             b_in,
    input  logic [DW-1:0]             m_in,
    input  logic                      v_in,
    output logic [DW-1:0]             p_out,
    output logic [DW-1:0]             a_out,
    output logic [DW-1:0]             q_out,
    output logic [carry_width(DW)-1:0] c_out,
    output logic [DW-1:0]             b_out,
    output logic [DW-1:0]             m_out,
    output logic                      v_out
);
    localparam int CW = carry_width(DW);
    localparam int SW = 2 * DW + 1;

    typedef struct packed {
        logic [DW-1:0] p;
        logic [DW-1:0] a;
        logic [DW-1:0] q;
        logic [CW-1:0] c;
        logic [DW-1:0] b1;
        logic [DW-1:0] b2;
        logic [DW-1:0] m1;
        logic [DW-1:0] m2;
        logic          v1;
        logic          v2;
    } cst_t;

    cst_t          st_d, st_q;
    logic [SW-1:0] sum_d;

    always_comb begin
        st_d  = st_q;
        sum_d = SW'(p_in) + SW'(a_in) * SW'(b_in) + SW'(q_in) * SW'(m_in) + SW'(c_in);
        st_d.p  = sum_d[DW-1:0];
        st_d.c  = sum_d[SW-1:DW];
        st_d.a  = a_in;
        st_d.q  = q_in;
        st_d.b1 = b_in;
        st_d.b2 = st_q.b1;
        st_d.m1 = m_in;
        st_d.m2 = st_q.m1;
        st_d.v1 = v_in;
        st_d.v2 = st_q.v1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign p_out = st_q.p;
    assign a_out = st_q.a;
    assign q_out = st_q.q;
    assign c_out = st_q.c;
    assign b_out = st_q.b2;
    assign m_out = st_q.m2;
    assign v_out = st_q.v2;
endmodule

// File: rtl/mont_systolic_mul.sv
module mont_systolic_mul import mm_pkg::*; #(
    parameter int DW = DIGIT_W_DEF,
    parameter int ND = N_DIGITS_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [ND*DW-1:0]     in_a,
    input  logic [(ND+1)*DW-1:0] in_b,
    input  logic [ND*DW-1:0]     in_m,
    input  logic [DW-1:0]        in_minv,
    output logic                 out_valid,
    output logic [(ND+2)*DW-1:0] out_p
);
    localparam int NR   = ND + 1;   // reduction steps
    localparam int NC   = ND + 3;   // digit columns
    localparam int NRES = NC - 1;   // result digits
    localparam int BDIG = ND + 1;   // multiplicand digits
    localparam int CW   = carry_width(DW);

    logic [DW-1:0] p_w [0:NR][0:NC-1];
    logic [DW-1:0] b_w [0:NR][0:NC-1];
    logic [DW-1:0] m_w [0:NR][0:NC-1];
    logic          v_w [0:NR][0:NC-1];
    logic [DW-1:0] k_w [0:NR];
    logic [DW-1:0] a_w [0:NR-1][0:NC];
    logic [DW-1:0] q_w [0:NR-1][1:NC];
    logic [CW-1:0] c_w [0:NR-1][1:NC];
    logic [NR*CW-1:0] spill_flat;

    // top edge: skew B, M and valid by column index
    generate
        for (genvar j = 0; j < NC; j++) begin : g_top
            assign p_w[0][j] = '0;
            if (j < BDIG) begin : g_b
                mm_delay #(.W(DW), .D(j)) u_bskew (
                    .clk(clk), .rst_n(rst_n),
                    .din(in_b[j*DW +: DW]), .dout(b_w[0][j]));
            end else begin : g_bz
                assign b_w[0][j] = '0;
            end
            if (j < ND) begin : g_m
                mm_delay #(.W(DW), .D(j)) u_mskew (
                    .clk(clk), .rst_n(rst_n),
                    .din(in_m[j*DW +: DW]), .dout(m_w[0][j]));
            end else begin : g_mz
                assign m_w[0][j] = '0;
            end
            mm_delay #(.W(1), .D(j)) u_vskew (
                .clk(clk), .rst_n(rst_n),
                .din(in_valid), .dout(v_w[0][j]));
        end

        // right edge: multiplier digit i enters 2i cycles late, top digit padded with zero
        for (genvar i = 0; i < NR; i++) begin : g_aedge
            if (i < ND) begin : g_a
                mm_delay #(.W(DW), .D(2*i)) u_askew (
                    .clk(clk), .rst_n(rst_n),
                    .din(in_a[i*DW +: DW]), .dout(a_w[i][0]));
            end else begin : g_az
                assign a_w[i][0] = '0;
            end
        end

        for (genvar i = 1; i <= NR; i++) begin : g_pz
            assign p_w[i][NC-1] = '0;
        end
    endgenerate

    assign k_w[0] = in_minv;

    // the grid
    generate
        for (genvar i = 0; i < NR; i++) begin : g_row
            for (genvar j = 0; j < NC; j++) begin : g_col
                if (j == 0) begin : g_q
                    mm_qcell #(.DW(DW)) u_qcell (
                        .clk(clk), .rst_n(rst_n),
                        .p_in(p_w[i][0]), .a_in(a_w[i][0]),
                        .b_in(b_w[i][0]), .m_in(m_w[i][0]),
                        .k_in(k_w[i]), .v_in(v_w[i][0]),
                        .a_out(a_w[i][1]), .q_out(q_w[i][1]), .c_out(c_w[i][1]),
                        .b_out(b_w[i+1][0]), .m_out(m_w[i+1][0]),
                        .k_out(k_w[i+1]), .v_out(v_w[i+1][0]));
                end else begin : g_g
                    mm_cell #(.DW(DW)) u_cell (
                        .clk(clk), .rst_n(rst_n),
                        .p_in(p_w[i][j]), .a_in(a_w[i][j]),
                        .q_in(q_w[i][j]), .c_in(c_w[i][j]),
                        .b_in(b_w[i][j]), .m_in(m_w[i][j]), .v_in(v_w[i][j]),
                        .p_out(p_w[i+1][j-1]), .a_out(a_w[i][j+1]),
                        .q_out(q_w[i][j+1]), .c_out(c_w[i][j+1]),
                        .b_out(b_w[i+1][j]), .m_out(m_w[i+1][j]), .v_out(v_w[i+1][j]));
                end
            end
            assign spill_flat[i*CW +: CW] = c_w[i][NC];
        end

        // bottom edge: realign result digits into one word
        for (genvar k = 0; k < NRES; k++) begin : g_out
            mm_delay #(.W(DW), .D(ND + 2 - k)) u_deskew (
                .clk(clk), .rst_n(rst_n),
                .din(p_w[NR][k]), .dout(out_p[k*DW +: DW]));
        end
    endgenerate

    assign out_valid = v_w[NR][NC-1];
endmodule

// File: rtl/mont_systolic_mul_chk.sv
module mont_systolic_mul_chk import mm_pkg::*; #(
    parameter int DW = DIGIT_W_DEF,
    parameter int ND = N_DIGITS_DEF
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [ND*DW-1:0]              in_m,
    input logic                          out_valid,
    input logic [(ND+2)*DW-1:0]          out_p,
    input logic [(ND+1)*carry_width(DW)-1:0] spill_flat
);
    localparam int LAT = pipe_latency(ND);

    logic [LAT-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[LAT-2:0], in_valid};
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spill_flat == '0);

    // R4 and R5: output valid is the input valid sequence shifted by the latency
    assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hist_q[LAT-1]);

    assert_reset_quiet_R6: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_p == '0));

    assert_top_digit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_p[(ND+1)*DW +: DW] == '0);

    assert_odd_modulus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_m[0]);
endmodule

bind mont_systolic_mul mont_systolic_mul_chk #(.DW(DW), .ND(ND)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_m(in_m),
    .out_valid(out_valid), .out_p(out_p), .spill_flat(spill_flat));

// File: tb/mont_systolic_mul_tb.sv
module mont_systolic_mul_tb;
    localparam int DW   = 2;
    localparam int ND   = 4;
    localparam int R    = 1 << DW;
    localparam int LAT  = 3 * ND + 4;
    localparam longint RPOW = longint'(R) ** (ND + 1);
    localparam int NTAB = 10;

    // stimulus: A, B, M, and expected A*B mod M
    localparam int TA [NTAB] = '{0, 255, 1, 123, 200, 7, 255, 64, 17, 99};
    localparam int TB [NTAB] = '{100, 509, 1, 45, 300, 0, 255, 191, 3, 400};
    localparam int TM [NTAB] = '{201, 255, 1, 187, 251, 13, 129, 97, 3, 233};
    localparam int TE [NTAB] = '{0, 0, 0, 112, 11, 0, 9, 2, 0, 223};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [ND*DW-1:0]     in_a = '0;
    logic [(ND+1)*DW-1:0] in_b = '0;
    logic [ND*DW-1:0]     in_m = '0;
    logic [DW-1:0]        in_minv = '0;
    logic                 out_valid;
    logic [(ND+2)*DW-1:0] out_p;

    mont_systolic_mul #(.DW(DW), .ND(ND)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
        .in_b(in_b), .in_m(in_m), .in_minv(in_minv),
        .out_valid(out_valid), .out_p(out_p));

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit expect_none = 1'b0;
    bit done = 1'b0;

    int q_a [256];
    int q_b [256];
    int q_m [256];
    int q_e [256];
    int q_c [256];
    int head = 0;
    int tail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int minv_of(input int m);
        int m0;
        m0 = m % R;
        for (int x = 0; x < R; x++) begin
            if ((((R - m0) * x) % R) == 1) return x;
        end
        return 0;
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic issue(input int a, input int b, input int m);
        @(negedge clk);
        in_valid = 1'b1;
        in_a     = (ND*DW)'(a);
        in_b     = ((ND+1)*DW)'(b);
        in_m     = (ND*DW)'(m);
        in_minv  = DW'(minv_of(m));
        q_a[tail % 256] = a;
        q_b[tail % 256] = b;
        q_m[tail % 256] = m;
        q_e[tail % 256] = int'((longint'(a) * longint'(b)) % longint'(m));
        q_c[tail % 256] = cyc;
        tail++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_a = '0;
        in_b = '0;
        in_m = '0;
        in_minv = '0;
    endtask

    // result monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expect_none || head == tail) begin
                check("R5 unexpected out_valid", 1, 0);
            end else begin
                longint x;
                int s;
                s = head % 256;
                x = longint'(out_p);
                check("R4 latency", cyc - q_c[s], LAT);
                check("R1 congruence", (x * RPOW) % q_m[s], q_e[s]);
                check("R1 below 2M", (x < 2 * q_m[s]) ? 1 : 0, 1);
                check("R7 top digit", longint'(out_p[(ND+1)*DW +: DW]), 0);
                if (q_a[s] == 0 || q_b[s] == 0) check("R8 zero operand", x, 0);
                if (q_m[s] == 1) check("R9 unit modulus", (x <= 1) ? 1 : 0, 1);
                head++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1234_5678;

        // R6: reset state
        repeat (3) @(negedge clk);
        check("R6 reset out_valid", longint'(out_valid), 0);
        check("R6 reset out_p", longint'(out_p), 0);
        rst_n = 1'b1;

        // table walk, back to back (R2)
        for (int t = 0; t < NTAB; t++) begin
            issue(TA[t], TB[t], TM[t]);
            check("R1 table expectation", q_e[(tail - 1) % 256], TE[t]);
        end
        idle();
        repeat (LAT + 4) @(negedge clk);
        check("R2 all table results", head, tail);

        // stream with bubbles: accepts overlap with emitted results
        for (int t = 0; t < 60; t++) begin
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >>> 17);
            seed = seed ^ (seed << 5);
            if ((seed & 3) == 0) begin
                idle();
            end else begin
                int m, a, b;
                m = ((seed >>> 4) & 255) | 1;
                a = (seed >>> 12) & 255;
                b = ((seed >>> 20) & 1023) % (2 * m);
                issue(a, b, m);
            end
        end
        idle();
        repeat (LAT + 4) @(negedge clk);
        check("R2 all stream results in order", head, tail);

        // R6: reset while operations are in flight
        for (int t = 0; t < 5; t++) issue(37 + t, 11 * t, 151);
        idle();
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        expect_none = 1'b1;
        @(negedge clk);
        check("R6 reset mid-flight out_valid", longint'(out_valid), 0);
        check("R6 reset mid-flight out_p", longint'(out_p), 0);
        @(negedge clk);
        head = tail;
        rst_n = 1'b1;
        repeat (LAT + 6) @(negedge clk);
        expect_none = 1'b0;
        check("R6 no stale results", head, tail);

        // single operation after reset, corner operands
        issue(255, 2 * 255 - 1, 255);
        issue(0, 0, 1);
        issue(128, 1, 3);
        idle();
        repeat (LAT + 4) @(negedge clk);
        check("R2 post-reset results", head, tail);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule